// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. Software sees two 32-bit registers on a simple single-cycle register bus. A control register at byte address 0x00 restarts the countdown. It does so only when the written word carries the restart bit together with a fixed 12-bit key, so that a stray store cannot keep a crashed system alive. A mode register at byte address 0x04 holds three things: a counter enable, a reset enable and a 4-bit interval code. The interval code selects one of eleven non-linear intervals, from 1 to 16 seconds.

A prescaler divides the input clock, whose frequency is the parameter `CLK_HZ`, into a one-second tick. The countdown consumes this tick. When the countdown runs out while the counter is enabled, the watchdog enters an expired state. If reset generation is also enabled at that moment, a reset output is driven high for `RST_CYCLES` clock cycles. The expired state lasts until a keyed restart or until counting is disabled.

The intended bring-up order has three steps:
1. Write the interval code with the enable bits clear.
2. Issue a keyed restart.
3. Write the same code with both enable bits set.

The register bus has no back-pressure. `bus_en` with `bus_we` high is a write that takes effect at the next clock edge. `bus_en` with `bus_we` low is a read, and `bus_rdata` presents the value in the same cycle.

Top module: `kwdog_top`

## Requirements
- R1: Only byte address 0x00 (control) and 0x04 (mode) are decoded. Writes to any other address change nothing. Reads of the control register, and of any undecoded address, return zero.
- R2: A control write causes a restart only when bit 0 is 1 and bits 12:1 equal 0xA57; bits 31:13 are don't-care. A control write with a different key, or with bit 0 clear, has no effect on the countdown.
- R3: The mode register keeps three fields: bit 0 is the count enable, bit 1 is the reset enable, and bits 6:3 are the interval code. Reads return those stored fields, with every other bit reading as zero.
- R4: Interval codes 1 to 11 select 1, 2, 3, 4, 5, 6, 8, 10, 12, 14 and 16 seconds respectively.
- R5: Code 0 and codes 12 to 15 select 16 seconds, so an interval of zero is never loaded.
- R6: With the enable set, expiry occurs exactly N*CLK_HZ clock edges after the later of two events: the edge that sets the enable, or the edge of the last keyed restart. N is the selected interval in seconds. A restart also clears the prescaler phase.
- R7: While the count enable is 0, the countdown does not advance. Writing zero to the mode register stops a running countdown, and no reset follows.
- R8: At expiry with both enables set, `wdt_reset_o` goes high for exactly RST_CYCLES cycles. If reset enable is 0 at expiry, no pulse occurs.
- R9: After expiry the block stays expired while it is enabled. It gives no further pulse, even if reset enable is set later, until a keyed restart starts a new countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_HZ cycles per second |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| wdt_reset_o | output | 1 | System reset request pulse |

## Verification
The assertions check several properties on every cycle:
- The mode fields hold their value unless the mode register is written.
- The countdown stays frozen while counting is disabled.
- Each restart loads a non-zero interval of at most 16.
- One-second ticks are never adjacent.
- A reset pulse can only start when both enables were set.
- The expired state persists until a restart or a disable.

Only the bench scenarios can show the remaining behaviour: the exact expiry cycle for every interval code, the pulse width, and that wrong keys or wrong addresses are ignored. The same holds for the absence of a second pulse after expiry, and for the effect of a mid-count restart on the prescaler phase.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;

  localparam logic [11:0] RESTART_KEY = 12'hA57;
  localparam int          SEC_W       = 5;

  typedef struct packed {
    logic [3:0] code;
    logic       rst_en;
    logic       cnt_en;
  } mode_t;

  // interval in seconds for a 4-bit code; unused codes fall back to 16
  function automatic logic [SEC_W-1:0] interval_of(input logic [3:0] code);
    logic [SEC_W-1:0] s;
    if (code >= 4'd1 && code <= 4'd6)
      s = SEC_W'(code);
    else if (code >= 4'd7 && code <= 4'd11)
      s = SEC_W'({code - 4'd3, 1'b0});
    else
      s = SEC_W'(16);
    return s;
  endfunction

endpackage

// File: rtl/kwdog_regs.sv
module kwdog_regs
  import kwdog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output mode_t             mode_o,
  output logic              restart_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(4);

  mode_t mode_q;
  logic  wr_ctrl, wr_mode;

  assign wr_ctrl = bus_en && bus_we && (bus_addr == A_CTRL);
  assign wr_mode = bus_en && bus_we && (bus_addr == A_MODE);

  assign restart_o = wr_ctrl && bus_wdata[0] && (bus_wdata[12:1] == RESTART_KEY);

  logic unused_wdata;
  assign unused_wdata = ^{bus_wdata[31:13], bus_wdata[2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (wr_mode) begin
      mode_q.cnt_en <= bus_wdata[0];
      mode_q.rst_en <= bus_wdata[1];
      mode_q.code   <= bus_wdata[6:3];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_we && bus_addr == A_MODE)
      bus_rdata = {25'd0, mode_q.code, 1'b0, mode_q.rst_en, mode_q.cnt_en};
  end

  assign mode_o = mode_q;

  p_mode_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q));

endmodule

// File: rtl/kwdog_tick.sv
module kwdog_tick #(
  parameter int CLK_HZ = 24_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clear_i,
  output logic tick_o
);

  generate
    if (CLK_HZ <= 1) begin : g_direct
      assign tick_o = run_i && !clear_i;
    end else begin : g_div
      localparam int PW = $clog2(CLK_HZ);
      localparam logic [PW-1:0] LAST = PW'(CLK_HZ - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  phase_q <= '0;
        else if (clear_i || !run_i)  phase_q <= '0;
        else if (phase_q == LAST)    phase_q <= '0;
        else                         phase_q <= phase_q + 1'b1;
      end

      assign tick_o = run_i && !clear_i && (phase_q == LAST);

      p_tick_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/kwdog_count.sv
module kwdog_count
  import kwdog_pkg::*;
#(
  parameter int RST_CYCLES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  mode_t      mode_i,
  input  logic       restart_i,
  input  logic       tick_i,
  output logic       expired_o,
  output logic       reset_o
);

  localparam int RW = $clog2(RST_CYCLES + 1);

  logic [SEC_W-1:0] secs_q;
  logic             expired_q;
  logic [RW-1:0]    pulse_q;
  logic             fire;

  assign fire = mode_i.cnt_en && !restart_i && !expired_q && tick_i && (secs_q <= SEC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q    <= SEC_W'(16);
      expired_q <= 1'b0;
    end else if (restart_i) begin
      secs_q    <= interval_of(mode_i.code);
      expired_q <= 1'b0;
    end else if (!mode_i.cnt_en) begin
      expired_q <= 1'b0;
    end else if (tick_i && !expired_q) begin
      if (fire) begin
        secs_q    <= '0;
        expired_q <= 1'b1;
      end else begin
        secs_q <= secs_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pulse_q <= '0;
    else if (fire && mode_i.rst_en)   pulse_q <= RW'(RST_CYCLES);
    else if (pulse_q != '0)           pulse_q <= pulse_q - 1'b1;
  end

  assign expired_o = expired_q;
  assign reset_o   = (pulse_q != '0);

  p_reload_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (secs_q != '0) && (secs_q <= SEC_W'(16)));

  p_no_count_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_i.cnt_en && !restart_i) |=> $stable(secs_q));

  p_rst_needs_enables_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_o) |-> $past(mode_i.cnt_en && mode_i.rst_en));

  p_stay_expired_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_q && mode_i.cnt_en && !restart_i) |=> expired_q);

endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int CLK_HZ     = 24_000_000,
  parameter int RST_CYCLES = 32,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_reset_o
);

  mode_t mode;
  logic  restart, tick, expired;

  kwdog_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .mode_o    (mode),
    .restart_o (restart)
  );

  kwdog_tick #(.CLK_HZ(CLK_HZ)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (mode.cnt_en && !expired),
    .clear_i (restart),
    .tick_o  (tick)
  );

  kwdog_count #(.RST_CYCLES(RST_CYCLES)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode),
    .restart_i (restart),
    .tick_i    (tick),
    .expired_o (expired),
    .reset_o   (wdt_reset_o)
  );

endmodule

// File: tb/test_kwdog_top.sv
module test_kwdog_top;

  localparam int F   = 8;
  localparam int RC  = 4;
  localparam int AW  = 8;
  localparam logic [31:0] KEY_OK = 32'h0000_14AF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          wdt_reset_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  kwdog_top #(.CLK_HZ(F), .RST_CYCLES(RC), .ADDR_W(AW)) i_kwdog_top (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_reset_o(wdt_reset_o));

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int secs_for(input int code);
    case (code)
      1, 2, 3, 4, 5, 6: return code;
      7: return 8;  8: return 10; 9: return 12; 10: return 14; 11: return 16;
      default: return 16;
    endcase
  endfunction

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = AW'(addr); bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = AW'(addr);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare every pulse start and width against the scoreboard
  int  width = 0;
  bit  prev = 0;
  always @(negedge clk) begin
    if (wdt_reset_o && !prev) begin
      if (exp_q.size() == 0) check(0, "R8/R9 unexpected pulse", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(cyc == e, "R6 expiry cycle", cyc, e);
      end
    end
    if (wdt_reset_o) width++;
    if (!wdt_reset_o && prev) begin
      check(width == RC, "R8 pulse width", width, RC);
      width = 0;
    end
    prev = wdt_reset_o;
  end

  task automatic run_code(input int code);
    int w;
    wr(4, 32'(code << 3));
    wr(0, KEY_OK);
    wr(4, 32'((code << 3) | 3));
    w = cyc;
    exp_q.push_back(w + secs_for(code) * F);
    idle(secs_for(code) * F + RC + 3);
  endtask

  initial begin
    #(8 * 200000);
    check(0, "watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w;
    idle(3); rst_n = 1; idle(2);
    // reset state
    check(wdt_reset_o == 0, "R8 reset output idle", wdt_reset_o, 0);
    rd(4, d); check(d == 0, "R3 mode reset value", d, 0);
    // R3 readback, bit 2 dropped
    wr(4, 32'hFFFF_FF7E);
    rd(4, d); check(d == 32'h7A, "R3 mode readback", d, 32'h7A);
    rd(0, d); check(d == 0, "R1 control reads zero", d, 0);
    // R1 undecoded address write ignored, read zero
    wr(8, 32'h0000_0013);
    rd(4, d); check(d == 32'h7A, "R1 stray write ignored", d, 32'h7A);
    rd(8, d); check(d == 0, "R1 undecoded read zero", d, 0);
    wr(4, 0);
    rd(4, d); check(d == 0, "R7 mode cleared", d, 0);

    // R4 / R5: every code
    for (int c = 0; c < 16; c++) run_code(c);

    // R2: bad keys during a count do not reload
    wr(4, 32'(2 << 3)); wr(0, KEY_OK); wr(4, 32'((2 << 3) | 3));
    w = cyc;
    exp_q.push_back(w + 2 * F);
    idle(5);
    wr(0, 32'h0000_14AD);   // wrong key
    wr(0, 32'h0000_14AE);   // bit 0 clear
    idle(2 * F + RC);
    check(exp_q.size() == 0, "R2 bad keys ignored", exp_q.size(), 0);

    // R6: mid-count restart reloads and clears prescaler phase
    wr(4, 32'(2 << 3)); wr(0, KEY_OK); wr(4, 32'((2 << 3) | 3));
    idle(11);
    wr(0, KEY_OK);
    w = cyc;
    exp_q.push_back(w + 2 * F);
    idle(2 * F + RC + 3);
    // R9: no further pulse while expired
    idle(4 * F);
    check(exp_q.size() == 0, "R9 single pulse", exp_q.size(), 0);

    // R8 without reset enable; then R9 late reset enable gives no pulse
    wr(4, 32'(1 << 3)); wr(0, KEY_OK); wr(4, 32'((1 << 3) | 1));
    idle(3 * F);
    wr(4, 32'((1 << 3) | 3));
    idle(3 * F);
    check(wdt_reset_o == 0, "R9 late reset enable silent", wdt_reset_o, 0);
    wr(0, KEY_OK);
    w = cyc;
    exp_q.push_back(w + F);
    idle(F + RC + 3);

    // R7: disable mid count, no reset
    wr(4, 32'(2 << 3)); wr(0, KEY_OK); wr(4, 32'((2 << 3) | 3));
    idle(6);
    wr(4, 0);
    idle(4 * F);
    check(wdt_reset_o == 0, "R7 disabled no reset", wdt_reset_o, 0);

    check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule